// File: doc/BRIEF.md
# Asynchronous host bus to Wishbone master bridge

This block lets a processor's asynchronous external-memory port reach on-chip Wishbone slaves. The host supplies a 12-bit word address, a 16-bit data bus and three active-low strobes: chip select, read enable and write enable. The bridge passes these through a two-stage synchronizer into the Wishbone clock domain. When it sees a valid access, it starts exactly one Wishbone transfer. The Wishbone address is a byte address, so it is one bit wider than the host word address and its least significant bit is always zero.

On a read, the slave's data is captured on the acknowledge edge and kept in a register. The bridge drives the host data bus only while chip select and read enable are both low. The bidirectional bus is modelled as an input bus, an output bus and an output-enable signal. The host side has no wait signal: the host must hold its strobes long enough for the transfer to complete. Address decoding toward individual slaves happens outside this block.

Top module: `hostbus_wb_bridge`

## Requirements
- R1: While reset is held, strobe, cycle, write-enable, the Wishbone address and the captured read data are all zero.
- R2: A transfer presents the Wishbone address as the host word address shifted left by one with bit 0 zero, and presents the host data as write data. Address, write data and write-enable stay stable until the transfer ends.
- R3: Strobe and cycle always carry the same value. They rise on the third rising clock edge after the host presents a valid access, which is two synchronizer stages plus one register.
- R4: Write-enable is 1 when host write enable is low and host read enable is high. It is 0 when host read enable is low and host write enable is high.
- R5: No transfer starts when chip select is high, when both host strobes are low, or when both host strobes are high.
- R6: Strobe and cycle fall on the clock edge at which acknowledge is sampled high. A held host access produces exactly one transfer, and the next transfer needs the access to be withdrawn and presented again.
- R7: On a read, the slave data present at the acknowledge edge is captured. It is held unchanged through later write acknowledges until the next read acknowledge.
- R8: The host data output enable is 1 exactly when raw chip select and raw read enable are both low, with no clock delay. While it is enabled, the host data output shows the captured read data.
- R9: If the host withdraws an access before acknowledge, strobe and cycle fall on the third rising edge after the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wishbone clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_oe_n | input | 1 | Host read enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | 12 | Host word address |
| host_data_i | input | 16 | Host data bus, value seen on the pins |
| host_data_o | output | 16 | Value the bridge places on the host data bus |
| host_data_oe | output | 1 | Host data bus drive enable |
| wb_adr_o | output | 13 | Wishbone byte address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Strobe, cycle, address, write data and write-enable are due on the third rising edge after the host presents an access. They fall on the edge that samples acknowledge, or on the third edge after an access is withdrawn. Captured read data appears one edge after a read acknowledge, and the host drive enable follows the raw pins within the same cycle. The bench changes host and slave inputs on falling edges and samples on falling edges. It counts whole cycles to the expected edge, and it also checks the cycle before the expected one, so that an early response is caught as well as a late one.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e state;
        logic        stb;
        logic        we;
    } xfer_ctl_t;

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16,
    localparam int WB_AW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             oe_n_s,
    input  logic             we_n_s,
    input  logic [AW-1:0]    addr_s,
    input  logic [DW-1:0]    data_s,
    input  logic             wb_ack_i,
    output logic [WB_AW-1:0] wb_adr_o,
    output logic [DW-1:0]    wb_dat_o,
    output logic             wb_stb_o,
    output logic             wb_cyc_o,
    output logic             wb_we_o
);

    xfer_ctl_t        ctl_d, ctl_q;
    logic [WB_AW-1:0] adr_d, adr_q;
    logic [DW-1:0]    wdat_d, wdat_q;
    logic             access_ok;

    // valid access: selected and exactly one direction strobe low
    assign access_ok = !cs_n_s && (oe_n_s != we_n_s);

    always_comb begin
        ctl_d  = ctl_q;
        adr_d  = adr_q;
        wdat_d = wdat_q;
        case (ctl_q.state)
            ST_IDLE: begin
                if (access_ok) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.stb   = 1'b1;
                    ctl_d.we    = !we_n_s;
                    adr_d       = {addr_s, 1'b0};
                    wdat_d      = data_s;
                end
            end
            ST_XFER: begin
                if (wb_ack_i) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.stb   = 1'b0;
                end else if (!access_ok) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.stb   = 1'b0;
                end
            end
            ST_HOLD: begin
                if (!access_ok) ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.stb   = 1'b0;
                ctl_d.we    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '{state: ST_IDLE, stb: 1'b0, we: 1'b0};
            adr_q  <= '0;
            wdat_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            adr_q  <= adr_d;
            wdat_q <= wdat_d;
        end
    end

    assign wb_adr_o = adr_q;
    assign wb_dat_o = wdat_q;
    assign wb_stb_o = ctl_q.stb;
    assign wb_cyc_o = ctl_q.stb;
    assign wb_we_o  = ctl_q.we;

    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_ack_i |=> !wb_stb_o); // R6

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && !wb_ack_i |=> $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)); // R2

    AST_START_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_stb_o) |-> $past(access_ok)); // R5

    AST_ADR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_stb_o) |-> (wb_adr_o[WB_AW-1:1] == $past(addr_s))); // R2

endmodule

// File: rtl/hbw_rdata.sv
module hbw_rdata #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_stb_i,
    input  logic          wb_we_i,
    input  logic          wb_ack_i,
    input  logic [DW-1:0] wb_dat_i,
    input  logic          host_cs_n,
    input  logic          host_oe_n,
    output logic [DW-1:0] host_data_o,
    output logic          host_data_oe
);

    logic [DW-1:0] rdata_d, rdata_q;
    logic          take;

    assign take = wb_ack_i && wb_stb_i && !wb_we_i;

    always_comb begin
        rdata_d = rdata_q;
        if (take) rdata_d = wb_dat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign host_data_o  = rdata_q;
    assign host_data_oe = !host_cs_n && !host_oe_n;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_ack_i && wb_stb_i && !wb_we_i) |=> $stable(host_data_o)); // R7

endmodule

// File: rtl/hostbus_wb_bridge.sv
module hostbus_wb_bridge #(
    parameter int AW          = 12,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WB_AW      = AW + 1,
    localparam int SW         = 3 + AW + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cs_n,
    input  logic             host_oe_n,
    input  logic             host_we_n,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_data_i,
    output logic [DW-1:0]    host_data_o,
    output logic             host_data_oe,
    output logic [WB_AW-1:0] wb_adr_o,
    output logic [DW-1:0]    wb_dat_o,
    input  logic [DW-1:0]    wb_dat_i,
    output logic             wb_stb_o,
    output logic             wb_cyc_o,
    output logic             wb_we_o,
    input  logic             wb_ack_i
);

    localparam logic [SW-1:0] SYNC_RST = {3'b111, {(AW + DW){1'b0}}};

    logic [SW-1:0] raw_bus, sync_bus;
    logic          cs_n_s, oe_n_s, we_n_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;

    assign raw_bus = {host_cs_n, host_oe_n, host_we_n, host_addr, host_data_i};
    assign {cs_n_s, oe_n_s, we_n_s, addr_s, data_s} = sync_bus;

    hbw_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_bus),
        .sync_o (sync_bus)
    );

    hbw_ctrl #(
        .AW(AW),
        .DW(DW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .oe_n_s  (oe_n_s),
        .we_n_s  (we_n_s),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .wb_ack_i(wb_ack_i),
        .wb_adr_o(wb_adr_o),
        .wb_dat_o(wb_dat_o),
        .wb_stb_o(wb_stb_o),
        .wb_cyc_o(wb_cyc_o),
        .wb_we_o (wb_we_o)
    );

    hbw_rdata #(
        .DW(DW)
    ) u_rdata (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_stb_i    (wb_stb_o),
        .wb_we_i     (wb_we_o),
        .wb_ack_i    (wb_ack_i),
        .wb_dat_i    (wb_dat_i),
        .host_cs_n   (host_cs_n),
        .host_oe_n   (host_oe_n),
        .host_data_o (host_data_o),
        .host_data_oe(host_data_oe)
    );

endmodule

// File: tb/hostbus_wb_bridge_bench.sv
module hostbus_wb_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic [11:0] host_addr = '0;
    logic [15:0] host_data_i = '0;
    logic [15:0] host_data_o;
    logic        host_data_oe;
    logic [12:0] wb_adr_o;
    logic [15:0] wb_dat_o;
    logic [15:0] wb_dat_i = '0;
    logic        wb_stb_o, wb_cyc_o, wb_we_o;
    logic        wb_ack_i = 1'b0;

    int          n_chk = 0;
    int          n_bad = 0;
    int          rises = 0;
    logic        prev_stb = 1'b0;
    logic [15:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    hostbus_wb_bridge u_hostbus_wb_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_addr(host_addr), .host_data_i(host_data_i),
        .host_data_o(host_data_o), .host_data_oe(host_data_oe),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_stb_o(wb_stb_o), .wb_cyc_o(wb_cyc_o), .wb_we_o(wb_we_o),
        .wb_ack_i(wb_ack_i)
    );

    always @(negedge clk) begin
        if (wb_stb_o && !prev_stb) rises++;
        prev_stb <= wb_stb_o;
    end

    function automatic logic [12:0] exp_adr(input logic [11:0] a);
        return {a, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_bus();
        host_cs_n = 1'b1; host_oe_n = 1'b1; host_we_n = 1'b1;
        #1;
        chk(host_data_oe == 1'b0, "R8 drive off after release", host_data_oe, 0);
        tick(4);
        chk(wb_stb_o == 1'b0, "R6 idle after release", wb_stb_o, 0);
    endtask

    task automatic access(input bit rd, input logic [11:0] a, input logic [15:0] d,
                          input logic [15:0] rv, input int dly);
        int r0;
        r0 = rises;
        host_addr = a; host_data_i = d;
        host_cs_n = 1'b0; host_oe_n = !rd; host_we_n = rd;
        #1;
        chk(host_data_oe == rd, "R8 drive enable follows pins", host_data_oe, rd);
        if (rd) chk(host_data_o == exp_rd, "R7 held data before ack", host_data_o, exp_rd);
        tick(2);
        chk(wb_stb_o == 1'b0, "R3 no strobe before third edge", wb_stb_o, 0);
        tick(1);
        chk(wb_stb_o && wb_cyc_o, "R3 strobe and cycle on third edge", {wb_stb_o, wb_cyc_o}, 2'b11);
        chk(wb_adr_o == exp_adr(a), "R2 byte address", wb_adr_o, exp_adr(a));
        chk(wb_we_o == !rd, "R4 write enable", wb_we_o, !rd);
        if (!rd) chk(wb_dat_o == d, "R2 write data", wb_dat_o, d);
        tick(dly);
        chk(wb_stb_o == 1'b1 && wb_adr_o == exp_adr(a), "R2 stable while waiting", wb_adr_o, exp_adr(a));
        wb_dat_i = rv; wb_ack_i = 1'b1;
        tick(1);
        wb_ack_i = 1'b0; wb_dat_i = 16'($urandom);
        chk(wb_stb_o == 1'b0 && wb_cyc_o == 1'b0, "R6 drop on ack edge", wb_stb_o, 0);
        if (rd) exp_rd = rv;
        if (rd) chk(host_data_o == exp_rd, "R7 captured read data", host_data_o, exp_rd);
        tick(4);
        chk(rises == r0 + 1, "R6 one transfer per access", rises - r0, 1);
        release_bus();
    endtask

    task automatic no_access(input logic cs, input logic oe, input logic we);
        int r0;
        r0 = rises;
        host_cs_n = cs; host_oe_n = oe; host_we_n = we;
        tick(6);
        chk(rises == r0 && !wb_stb_o, "R5 no transfer for invalid strobes", rises - r0, 0);
        #1;
        chk(host_data_oe == (!cs && !oe), "R8 enable on invalid combo", host_data_oe, (!cs && !oe));
        release_bus();
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        chk(!wb_stb_o && !wb_cyc_o && !wb_we_o, "R1 reset controls", {wb_stb_o, wb_cyc_o, wb_we_o}, 0);
        chk(wb_adr_o == 13'd0 && host_data_o == 16'd0, "R1 reset address and data", wb_adr_o, 0);
        rst_n = 1'b1;
        tick(4);

        // directed corners
        access(1'b0, 12'hFFF, 16'hA5A5, 16'h0000, 0);
        access(1'b1, 12'h000, 16'h0000, 16'h1234, 0);
        access(1'b0, 12'h800, 16'hFFFF, 16'hDEAD, 2); // write ack data must not touch R7 capture
        access(1'b1, 12'h7FF, 16'h0000, 16'hBEEF, 3);
        no_access(1'b0, 1'b0, 1'b0);
        no_access(1'b0, 1'b1, 1'b1);
        no_access(1'b1, 1'b0, 1'b1);
        no_access(1'b1, 1'b1, 1'b0);

        // R9: withdrawal before ack
        host_addr = 12'h155; host_cs_n = 1'b0; host_oe_n = 1'b0; host_we_n = 1'b1;
        tick(3);
        chk(wb_stb_o == 1'b1, "R9 transfer started", wb_stb_o, 1);
        host_cs_n = 1'b1; host_oe_n = 1'b1;
        tick(2);
        chk(wb_stb_o == 1'b1, "R9 still active two edges after withdrawal", wb_stb_o, 1);
        tick(1);
        chk(wb_stb_o == 1'b0, "R9 dropped on third edge", wb_stb_o, 0);
        tick(4);

        // random mix
        for (int i = 0; i < 150; i++) begin
            access(1'($urandom), 12'($urandom), 16'($urandom), 16'($urandom), int'($urandom_range(0, 3)));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule